// File: doc/BRIEF.md
# Multiprocessor Control and Inter-Processor Interrupt Unit

This block sits on a simple register bus shared by a small cluster of CPUs. Every request carries the id of the CPU that issues it, so the unit can answer "who am I" and "how many of us are there". It also serves per-CPU requests on that CPU's own interrupt queue. Software on the boot CPU uses it to load a boot address and a boot stack value, to launch secondary CPUs, and to pause or release them. Any CPU can post inter-processor interrupts (IPIs) to one peer or to all peers but one.

Each CPU owns an 8-entry IPI queue and one interrupt line. The line is high while that queue holds anything. A CPU drains its queue by reading the pop register, which returns the oldest IPI number, or 0 when the queue is empty. A pseudo-random word, a free-running cycle count and a constant memory size complete the register set.

Each CPU's run state is a small state machine with three states:
- `CS_IDLE`: the CPU has not been launched.
- `CS_RUN`: the CPU is running.
- `CS_HOLD`: the CPU is launched but paused.

It has four transitions:
- T_BOOT: `CS_IDLE` to `CS_RUN` on a start.
- T_RESTART: `CS_RUN` to `CS_RUN` on a start.
- T_SUSPEND: `CS_RUN` to `CS_HOLD` on a pause-others write that does not name this CPU.
- T_RESUME: `CS_HOLD` to `CS_RUN` on a release or a start.

Every other event leaves the state as it is.

Top module: `mpc_unit`

## Requirements

Register offsets are byte addresses on `req_addr`. A request is decoded only when `req_addr[3:0]` is 0. The read data appears on `rsp_rdata` with `rsp_valid` in the cycle after the request.

- R1: A read at offset 0x00 returns the requester id from `req_cpu`, zero-extended. A read at 0x10 returns the parameter NCPU.
- R2: A write of value i at 0x20 starts CPU i, if i < NCPU. This drives `cpu_start[i]` high for exactly one cycle and takes the CPU to `CS_RUN` (`cpu_run[i]`=1). It also latches, for that CPU only, `cpu_boot_pc` slice i from the last word written at 0x30 and `cpu_boot_sp` slice i from the last word written at 0x70. Those slices keep their values when the shared registers change later. A value i ≥ NCPU starts nothing.
- R3: A write of i at 0x50 moves every CPU other than i that is in `CS_RUN` into `CS_HOLD` (`cpu_hold`=1, `cpu_run`=0). CPUs in `CS_IDLE` stay idle.
- R4: A write of i at 0x60 moves CPU i from `CS_HOLD` to `CS_RUN`. A start of a CPU in `CS_HOLD` also moves it to `CS_RUN`.
- R5: A write at 0xA0 carries the IPI number in bits 31:16 and the target id in bits 15:0. It appends the number to that target's queue only, and the target's `cpu_irq` bit is high from the next cycle.
- R6: A write at 0xB0 with the same layout appends the number to the queue of every CPU except the named one. A named id ≥ NCPU reaches all CPUs.
- R7: A read at 0xC0 removes the requester's oldest IPI and returns it in bits 15:0, in the order of arrival. On an empty queue the read returns 0 in bits 15:0. `cpu_irq[j]` is 1 exactly while queue j is non-empty.
- R8: A write at 0xC0 empties the requester's queue and clears its overflow flag. Other queues are not affected.
- R9: Each queue holds 8 entries. An IPI sent to a full queue is dropped and sets that queue's sticky overflow flag, which reads as bit 31 of every 0xC0 read until a flush.
- R10: An IPI whose number is 0 is not queued.
- R11: A read at 0x80 returns a 32-bit state that is never 0. It advances once per clock by s' = (s >> 1) XOR (s[0] ? 0x80200003 : 0), so two reads issued in consecutive cycles r1, r2 satisfy r2 = step(r1).
- R12: A read at 0xD0 returns a cycle count that grows by exactly one per clock, so reads issued k cycles apart differ by k.
- R13: `req_size` is 0 for byte, 1 for half-word and 2 or 3 for word. Read data and write data are masked to the low 8, 16 or 32 bits. A request with `req_addr[3:0]` ≠ 0 reads 0 and has no effect, including no pop.
- R14: A read at 0x90 returns the parameter MEM_BYTES.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_size | input | 2 | Access width: 0 byte, 1 half, 2/3 word |
| req_cpu | input | ID_W | Id of the requesting CPU |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| cpu_start | output | NCPU | One-cycle start pulse per CPU |
| cpu_run | output | NCPU | CPU is in CS_RUN |
| cpu_hold | output | NCPU | CPU is in CS_HOLD |
| cpu_boot_pc | output | NCPU*32 | Boot address latched at start, slice per CPU |
| cpu_boot_sp | output | NCPU*32 | Boot stack value latched at start, slice per CPU |
| cpu_irq | output | NCPU | IPI pending per CPU |

## Verification

The bench builds the unit with NCPU = 3 and the default queue depth of 8. A cluster size that is not a power of two leaves one encodable id (3) that names no CPU. The bench uses it to exercise out-of-range starts, broadcasts that exclude no real CPU, and requester ids that own no queue. The 8-entry depth is small enough that the random traffic and a directed burst of ten IPIs both push queues into overflow, so the sticky flag and the drop rule are checked against a per-CPU reference queue.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int DATA_W = 32;
    localparam int IPI_W  = 16;

    // register index = req_addr[7:4]
    localparam logic [3:0] IX_WHOAMI = 4'h0;
    localparam logic [3:0] IX_COUNT  = 4'h1;
    localparam logic [3:0] IX_START  = 4'h2;
    localparam logic [3:0] IX_BOOTPC = 4'h3;
    localparam logic [3:0] IX_HOLDX  = 4'h5;
    localparam logic [3:0] IX_RELSE  = 4'h6;
    localparam logic [3:0] IX_BOOTSP = 4'h7;
    localparam logic [3:0] IX_RANDOM = 4'h8;
    localparam logic [3:0] IX_MEMSZ  = 4'h9;
    localparam logic [3:0] IX_IPI1   = 4'hA;
    localparam logic [3:0] IX_IPIN   = 4'hB;
    localparam logic [3:0] IX_IPIQ   = 4'hC;
    localparam logic [3:0] IX_CYCLES = 4'hD;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_RUN  = 2'd1,
        CS_HOLD = 2'd2
    } core_state_e;

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_mask = 32'h0000_00FF;
            2'd1:    size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/mpc_ipi_q.sv
module mpc_ipi_q #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full, do_push, do_pop;

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt      <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            if (push && full && !do_pop) begin
                overflow <= 1'b1;
            end
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);  // R9
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (overflow && $stable(cnt)));  // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !overflow));  // R8

endmodule

// File: rtl/mpc_core_seq.sv
module mpc_core_seq
    import mpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_hit,
    input  logic hold_hit,
    input  logic release_hit,
    output logic run,
    output logic hold,
    output logic start_pulse
);
    core_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE: begin
                if (start_hit) state_d = CS_RUN;            // T_BOOT
            end
            CS_RUN: begin
                if (start_hit)     state_d = CS_RUN;        // T_RESTART
                else if (hold_hit) state_d = CS_HOLD;       // T_SUSPEND
            end
            CS_HOLD: begin
                if (start_hit || release_hit) state_d = CS_RUN; // T_RESUME
            end
            default: state_d = CS_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= start_hit;
        end
    end

    always_comb begin
        run  = (state_q == CS_RUN);
        hold = (state_q == CS_HOLD);
    end

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |=> (run && start_pulse));  // R2
    AST_IDLE_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_hit && !start_hit && state_q == CS_IDLE) |=> !hold);  // R3
    AST_RELEASE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (release_hit && hold) |=> run);  // R4

endmodule

// File: rtl/mpc_lfsr.sv
module mpc_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'h1ACE_B00C
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= SEED;
        end else begin
            value <= (value >> 1) ^ (value[0] ? MASK : '0);
        end
    end

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        value != '0);  // R11

endmodule

// File: rtl/mpc_unit.sv
module mpc_unit
    import mpc_pkg::*;
#(
    parameter int          NCPU      = 4,
    parameter int          QDEPTH    = 8,
    parameter logic [31:0] MEM_BYTES = 32'h0800_0000,
    parameter int          ID_W      = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_we,
    input  logic [7:0]           req_addr,
    input  logic [1:0]           req_size,
    input  logic [ID_W-1:0]      req_cpu,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic [NCPU-1:0]      cpu_start,
    output logic [NCPU-1:0]      cpu_run,
    output logic [NCPU-1:0]      cpu_hold,
    output logic [NCPU*32-1:0]   cpu_boot_pc,
    output logic [NCPU*32-1:0]   cpu_boot_sp,
    output logic [NCPU-1:0]      cpu_irq
);
    logic [3:0]        idx;
    logic              acc_ok;
    logic [31:0]       mask, wd, rd_val;
    logic [IPI_W-1:0]  ipi_num;
    logic [15:0]       ipi_tgt;
    logic [31:0]       pc_q, sp_q, cyc_q, rnd;
    logic              wr_start, wr_hold, wr_rel, wr_one, wr_many, wr_q, rd_q;

    logic [IPI_W-1:0]  q_head [NCPU];
    logic [NCPU-1:0]   q_empty, q_ovf;

    assign idx     = req_addr[7:4];
    assign acc_ok  = req_valid && (req_addr[3:0] == 4'h0);
    assign mask    = size_mask(req_size);
    assign wd      = req_wdata & mask;
    assign ipi_num = wd[31:16];
    assign ipi_tgt = wd[15:0];

    assign wr_start = acc_ok && req_we && (idx == IX_START);
    assign wr_hold  = acc_ok && req_we && (idx == IX_HOLDX);
    assign wr_rel   = acc_ok && req_we && (idx == IX_RELSE);
    assign wr_one   = acc_ok && req_we && (idx == IX_IPI1) && (ipi_num != '0);
    assign wr_many  = acc_ok && req_we && (idx == IX_IPIN) && (ipi_num != '0);
    assign wr_q     = acc_ok && req_we && (idx == IX_IPIQ);
    assign rd_q     = acc_ok && !req_we && (idx == IX_IPIQ);

    // shared boot registers and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            sp_q  <= '0;
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 32'd1;
            if (acc_ok && req_we && idx == IX_BOOTPC) pc_q <= wd;
            if (acc_ok && req_we && idx == IX_BOOTSP) sp_q <= wd;
        end
    end

    mpc_lfsr #(.W(32)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    for (genvar j = 0; j < NCPU; j++) begin : g_cpu
        logic st_hit, hd_hit, rl_hit, push, pop, flush;

        assign st_hit = wr_start && (wd == 32'(j));
        assign hd_hit = wr_hold  && (wd != 32'(j));
        assign rl_hit = wr_rel   && (wd == 32'(j));
        assign push   = (wr_one && ipi_tgt == 16'(j)) || (wr_many && ipi_tgt != 16'(j));
        assign pop    = rd_q && (req_cpu == ID_W'(j));
        assign flush  = wr_q && (req_cpu == ID_W'(j));

        mpc_core_seq u_seq (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_hit   (st_hit),
            .hold_hit    (hd_hit),
            .release_hit (rl_hit),
            .run         (cpu_run[j]),
            .hold        (cpu_hold[j]),
            .start_pulse (cpu_start[j])
        );

        mpc_ipi_q #(.DEPTH(QDEPTH), .W(IPI_W)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push),
            .push_data (ipi_num),
            .pop       (pop),
            .flush     (flush),
            .head      (q_head[j]),
            .empty     (q_empty[j]),
            .overflow  (q_ovf[j])
        );

        assign cpu_irq[j] = !q_empty[j];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cpu_boot_pc[j*32 +: 32] <= '0;
                cpu_boot_sp[j*32 +: 32] <= '0;
            end else if (st_hit) begin
                cpu_boot_pc[j*32 +: 32] <= pc_q;
                cpu_boot_sp[j*32 +: 32] <= sp_q;
            end
        end
    end

    // read mux
    always_comb begin
        rd_val = '0;
        if (acc_ok && !req_we) begin
            case (idx)
                IX_WHOAMI: rd_val = 32'(req_cpu);
                IX_COUNT:  rd_val = 32'(NCPU);
                IX_RANDOM: rd_val = rnd;
                IX_MEMSZ:  rd_val = MEM_BYTES;
                IX_CYCLES: rd_val = cyc_q;
                IX_IPIQ: begin
                    for (int j = 0; j < NCPU; j++) begin
                        if (req_cpu == ID_W'(j)) begin
                            rd_val = {q_ovf[j], 15'd0, (q_empty[j] ? '0 : q_head[j])};
                        end
                    end
                end
                default: rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_we;
            rsp_rdata <= rd_val & mask;
        end
    end

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_start));  // R2
    AST_MISALIGNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && req_addr[3:0] != 4'h0) |=> (rsp_rdata == '0));  // R13

endmodule

// File: tb/mpc_unit_tb_top.sv
`timescale 1ns/1ps
module mpc_unit_tb_top;
    localparam int NC = 3;
    localparam int QD = 8;
    localparam logic [31:0] MEMB = 32'h0400_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_we = 1'b0;
    logic [7:0]      req_addr = '0;
    logic [1:0]      req_size = 2'd2;
    logic [1:0]      req_cpu = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [NC-1:0]   cpu_start, cpu_run, cpu_hold, cpu_irq;
    logic [NC*32-1:0] cpu_boot_pc, cpu_boot_sp;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    mpc_unit #(.NCPU(NC), .QDEPTH(QD), .MEM_BYTES(MEMB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_size(req_size), .req_cpu(req_cpu),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cpu_start(cpu_start), .cpu_run(cpu_run), .cpu_hold(cpu_hold),
        .cpu_boot_pc(cpu_boot_pc), .cpu_boot_sp(cpu_boot_sp), .cpu_irq(cpu_irq)
    );

    // reference queues
    logic [15:0] mq [NC][QD];
    int          mc [NC];
    bit          mo [NC];

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access; called and returns at a negative edge
    task automatic acc(input logic we, input logic [7:0] a, input logic [1:0] sz,
                       input logic [1:0] cpu, input logic [31:0] d, output logic [31:0] rd);
        req_valid = 1'b1; req_we = we; req_addr = a; req_size = sz;
        req_cpu = cpu; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        rd = rsp_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] cpu, input logic [31:0] d);
        logic [31:0] x;
        acc(1'b1, a, 2'd2, cpu, d, x);
    endtask

    task automatic rdw(input logic [7:0] a, input logic [1:0] cpu, output logic [31:0] rd);
        acc(1'b0, a, 2'd2, cpu, 32'h0, rd);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_push(input int c, input logic [15:0] num);
        if (num != 16'h0) begin
            if (mc[c] == QD) mo[c] = 1'b1;
            else begin mq[c][mc[c]] = num; mc[c]++; end
        end
    endtask

    function automatic logic [31:0] m_pop(input int c);
        logic [31:0] v;
        v = {mo[c], 15'd0, (mc[c] > 0) ? mq[c][0] : 16'h0};
        if (mc[c] > 0) begin
            for (int k = 0; k < QD - 1; k++) mq[c][k] = mq[c][k+1];
            mc[c]--;
        end
        return v;
    endfunction

    function automatic logic [NC-1:0] m_irq();
        logic [NC-1:0] v;
        for (int c = 0; c < NC; c++) v[c] = (mc[c] != 0);
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r, r2;
        void'($urandom(32'd20240611));
        for (int c = 0; c < NC; c++) begin mc[c] = 0; mo[c] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        chk("R2 reset run", 32'(cpu_run), 0);
        chk("R2 reset start", 32'(cpu_start), 0);
        chk("R7 reset irq", 32'(cpu_irq), 0);
        chk("R2 reset boot pc", cpu_boot_pc[31:0], 0);

        // R1 identity and count, R14 memory size
        for (int c = 0; c < 4; c++) begin
            rdw(8'h00, 2'(c), r);
            chk("R1 whoami", r, 32'(c));
        end
        rdw(8'h10, 2'd1, r); chk("R1 count", r, NC);
        rdw(8'h90, 2'd0, r); chk("R14 mem size", r, MEMB);

        // R2 start with boot values
        wr(8'h30, 0, 32'h0000_1000);
        wr(8'h70, 0, 32'h0000_2000);
        wr(8'h20, 0, 32'd1);
        chk("R2 start pulse", 32'(cpu_start), 32'b010);
        chk("R2 run", 32'(cpu_run), 32'b010);
        chk("R2 boot pc", cpu_boot_pc[63:32], 32'h1000);
        chk("R2 boot sp", cpu_boot_sp[63:32], 32'h2000);
        idle(1);
        chk("R2 pulse one cycle", 32'(cpu_start), 0);
        wr(8'h30, 0, 32'h0000_3000);
        wr(8'h20, 0, 32'd2);
        chk("R2 per-cpu pc cpu2", cpu_boot_pc[95:64], 32'h3000);
        chk("R2 per-cpu pc cpu1 kept", cpu_boot_pc[63:32], 32'h1000);
        wr(8'h20, 0, 32'd3);
        chk("R2 out of range start", 32'(cpu_start), 0);
        chk("R2 out of range run", 32'(cpu_run), 32'b110);

        // R3 pause others; cpu0 idle stays idle
        wr(8'h50, 0, 32'd1);
        chk("R3 hold", 32'(cpu_hold), 32'b100);
        chk("R3 run", 32'(cpu_run), 32'b010);
        // R4 release and start-from-hold
        wr(8'h60, 0, 32'd2);
        chk("R4 release", 32'(cpu_run), 32'b110);
        wr(8'h20, 0, 32'd0);
        chk("R4 start cpu0", 32'(cpu_run), 32'b111);
        wr(8'h50, 0, 32'd0);
        chk("R3 hold others", 32'(cpu_hold), 32'b110);
        wr(8'h20, 0, 32'd1);
        chk("R4 start from hold", 32'(cpu_run), 32'b011);
        // R13 byte write truncation: 0x0102 as byte -> 2
        acc(1'b1, 8'h60, 2'd0, 0, 32'h0000_0102, r);
        chk("R13 byte write truncated", 32'(cpu_run), 32'b111);
        // R13 misaligned write has no effect
        wr(8'h50, 0, 32'd0);
        acc(1'b1, 8'h61, 2'd2, 0, 32'd1, r);
        chk("R13 misaligned write ignored", 32'(cpu_hold), 32'b110);

        // R5 unicast
        wr(8'hA0, 1, {16'd5, 16'd2});
        chk("R5 unicast irq", 32'(cpu_irq), 32'b100);
        rdw(8'hC0, 2'd2, r); chk("R5 pop value", r, 5);
        chk("R7 irq clears", 32'(cpu_irq), 0);
        rdw(8'hC0, 2'd2, r); chk("R7 empty pop", r, 0);
        // R6 broadcast
        wr(8'hB0, 0, {16'd7, 16'd1});
        chk("R6 broadcast irq", 32'(cpu_irq), 32'b101);
        rdw(8'hC0, 2'd0, r); chk("R6 cpu0", r, 7);
        rdw(8'hC0, 2'd2, r); chk("R6 cpu2", r, 7);
        rdw(8'hC0, 2'd1, r); chk("R6 excluded cpu1", r, 0);
        wr(8'hB0, 0, {16'd9, 16'd3});
        chk("R6 id out of range reaches all", 32'(cpu_irq), 32'b111);
        for (int c = 0; c < NC; c++) begin rdw(8'hC0, 2'(c), r); chk("R6 all pop", r, 9); end
        // R7 ordering
        wr(8'hA0, 1, {16'd3, 16'd0});
        wr(8'hA0, 1, {16'd4, 16'd0});
        wr(8'hA0, 1, {16'd9, 16'd0});
        rdw(8'hC0, 2'd0, r); chk("R7 order 1", r, 3);
        rdw(8'hC0, 2'd0, r); chk("R7 order 2", r, 4);
        rdw(8'hC0, 2'd0, r); chk("R7 order 3", r, 9);
        // R10 zero ignored
        wr(8'hA0, 1, {16'd0, 16'd0});
        chk("R10 zero not queued", 32'(cpu_irq), 0);
        // R9 overflow
        for (int k = 1; k <= 10; k++) wr(8'hA0, 0, {16'(k), 16'd1});
        rdw(8'hC0, 2'd1, r); chk("R9 overflow flag", r, 32'h8000_0001);
        for (int k = 2; k <= 8; k++) begin rdw(8'hC0, 2'd1, r); chk("R9 kept entries", r, 32'h8000_0000 | k); end
        rdw(8'hC0, 2'd1, r); chk("R9 dropped tail", r, 32'h8000_0000);
        // R8 flush
        wr(8'hC0, 1, 0);
        rdw(8'hC0, 2'd1, r); chk("R8 flush clears flag", r, 0);
        wr(8'hA0, 0, {16'd2, 16'd2});
        wr(8'hA0, 0, {16'd2, 16'd0});
        wr(8'hC0, 2, 0);
        chk("R8 flush own queue only", 32'(cpu_irq), 32'b001);
        rdw(8'hC0, 2'd0, r); chk("R8 other queue kept", r, 2);

        // R13 narrow reads and misaligned pop
        wr(8'hA0, 0, {16'h1234, 16'd0});
        wr(8'hA0, 0, {16'h1234, 16'd0});
        acc(1'b0, 8'hC0, 2'd0, 0, 0, r); chk("R13 byte read", r, 32'h34);
        acc(1'b0, 8'hC0, 2'd1, 0, 0, r); chk("R13 half read", r, 32'h1234);
        wr(8'hA0, 0, {16'd6, 16'd2});
        acc(1'b0, 8'hC4, 2'd2, 2, 0, r); chk("R13 misaligned read zero", r, 0);
        chk("R13 misaligned no pop", 32'(cpu_irq), 32'b100);
        rdw(8'hC0, 2'd2, r); chk("R13 entry still there", r, 6);

        // R11 random, R12 cycles
        rdw(8'h80, 0, r); rdw(8'h80, 0, r2);
        chk("R11 nonzero", 32'(r != 0), 1);
        chk("R11 step", r2, lfsr_step(r));
        rdw(8'hD0, 0, r); rdw(8'hD0, 0, r2);
        chk("R12 one cycle", r2 - r, 1);
        rdw(8'hD0, 0, r); idle(5); rdw(8'hD0, 0, r2);
        chk("R12 six cycles", r2 - r, 6);

        // random IPI traffic against the reference queues
        for (int c = 0; c < NC; c++) wr(8'hC0, 2'(c), 0);
        for (int i = 0; i < 400; i++) begin
            int op, c; logic [15:0] num;
            op  = int'($urandom_range(0, 9));
            c   = int'($urandom_range(0, 3));
            num = ($urandom_range(0, 9) == 0) ? 16'h0 : 16'($urandom_range(1, 16'hFFFF));
            if (op < 4) begin
                wr(8'hA0, 0, {num, 16'(c)});
                if (c < NC) m_push(c, num);
            end else if (op < 6) begin
                wr(8'hB0, 0, {num, 16'(c)});
                for (int t = 0; t < NC; t++) if (t != c) m_push(t, num);
            end else if (op < 9) begin
                rdw(8'hC0, 2'(c), r);
                if (c < NC) chk("R7 random pop", r, m_pop(c));
                else chk("R7 pop without queue", r, 0);
            end else begin
                wr(8'hC0, 2'(c), 0);
                if (c < NC) begin mc[c] = 0; mo[c] = 1'b0; end
            end
            chk("R9 random irq", 32'(cpu_irq), 32'(m_irq()));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule